// File: doc/BRIEF.md
# System Tick Timer

A periodic down-counter placed on a simple 32-bit register bus with separate write and read strobes. Software programs a reload value, selects whether the counter advances on every core clock cycle or only on pulses of an external reference tick, and turns the timer on. The counter loads the reload value, counts down to zero and expires on the next tick after zero. Each period is therefore reload+1 ticks long. On every expiry a sticky flag is set, and an optional one-cycle interrupt pulse is sent to the interrupt controller.

Four word registers are decoded: control/status, reload, current count and a read-only calibration constant. Reading control/status clears the sticky flag. Any write to the current-count register restarts the period. When software turns the timer off, the count freezes, and turning it back on resumes from the frozen value. A zero reload value gives a single-shot timer that switches itself off when it expires.

Top module: `systick_timer`

## Requirements
- R1: After reset, control/status, reload and current count all read 0, and `tick_irq` is low.
- R2: The only decoded byte addresses are 0x0 (control/status), 0x4 (reload), 0x8 (current count) and 0xC (calibration), and each must match exactly. Any other address, misaligned ones included, reads 0 and writes to it change nothing. `bus_rdata` is 0 whenever `bus_rd` is low.
- R3: The control/status layout is: bit 0 enable, bit 1 interrupt enable, bit 2 clock source (1 = core clock, 0 = reference tick) and bit 16 the sticky expiry flag. All other bits read 0. A write changes only bits 2:0.
- R4: A read of control/status returns the flag as it stood before the read and clears it at the following edge. An expiry in that same cycle sets the flag instead.
- R5: When enable changes from 0 to 1 with no frozen count pending, the counter loads the reload value. Each later tick decrements it, and the tick taken at count 0 is the expiry. Current count reads the live count while enabled and 0 while disabled.
- R6: On expiry the flag is set. If interrupt enable is 1, `tick_irq` is high for exactly the one cycle after the expiry edge; otherwise it stays low.
- R7: An expiry with reload equal to 0 clears enable and stops the counter.
- R8: A write of any data to current count clears the flag. If the timer is enabled, the write also reloads the counter from the reload value. If the timer is disabled, the write discards any frozen count, so the next enable loads afresh.
- R9: With clock source 1 the counter ticks every cycle. With clock source 0 it ticks only on `ref_tick` pulses, which arrive one cycle late when EXT_TICK_REG is 1.
- R10: Changing the clock-source bit while enable stays 1 reloads the counter from the reload value.
- R11: Clearing enable freezes the count. Setting enable again with no write to current count in between resumes from the frozen value.
- R12: The reload register keeps the low COUNT_W bits of the written data and reads back zero-extended.
- R13: Calibration always reads CAL_VALUE (10000 by default) and ignores writes.
- R14: In a cycle that writes control/status or current count, the counter does not take a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational, valid in the strobe cycle |
| ref_tick | input | 1 | One-cycle reference tick pulse in the clk domain |
| tick_irq | output | 1 | One-cycle interrupt request pulse on expiry |

## Verification
The bench builds the block with COUNT_W set to 12 and EXT_TICK_REG set to 1. The other parameters keep their defaults. The narrow counter lets reload values wider than the counter be written, so truncation and zero-extended read-back can be exercised cheaply. The registered tick path makes the one-cycle lag of reference ticks visible in every period measured on that source. A behavioural model runs alongside and is compared on every cycle. It covers directed sequences and a long pseudo-random mix of small reloads, control writes, restarts and flag reads, which brings expiry-versus-read and write-versus-tick collisions within reach.

// File: rtl/systick_pkg.sv
package systick_pkg;

   // byte offsets of the register window
   localparam int unsigned OFS_CTRL   = 32'h0;
   localparam int unsigned OFS_RELOAD = 32'h4;
   localparam int unsigned OFS_COUNT  = 32'h8;
   localparam int unsigned OFS_CALIB  = 32'hC;

   // control/status bit positions
   localparam int BIT_RUN   = 0;
   localparam int BIT_IRQEN = 1;
   localparam int BIT_SRC   = 2;
   localparam int BIT_FLAG  = 16;

   typedef enum logic [2:0] {
      RSEL_NONE,
      RSEL_CTRL,
      RSEL_RELOAD,
      RSEL_COUNT,
      RSEL_CALIB
   } rsel_e;

   typedef struct packed {
      logic wr_ctrl;
      logic wr_reload;
      logic wr_count;
      logic rd_ctrl;
   } strobe_t;

endpackage

// File: rtl/systick_decode.sv
module systick_decode
   import systick_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   output strobe_t           stb,
   output rsel_e             rsel
);

   localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFS_RELOAD);
   localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
   localparam logic [ADDR_W-1:0] A_CALIB  = ADDR_W'(OFS_CALIB);

   always_comb begin
      stb.wr_ctrl   = wr && (addr == A_CTRL);
      stb.wr_reload = wr && (addr == A_RELOAD);
      stb.wr_count  = wr && (addr == A_COUNT);
      stb.rd_ctrl   = rd && (addr == A_CTRL);
      rsel          = RSEL_NONE;
      if (rd) begin
         unique case (addr)
            A_CTRL:   rsel = RSEL_CTRL;
            A_RELOAD: rsel = RSEL_RELOAD;
            A_COUNT:  rsel = RSEL_COUNT;
            A_CALIB:  rsel = RSEL_CALIB;
            default:  rsel = RSEL_NONE;
         endcase
      end
   end

endmodule

// File: rtl/systick_tick_sel.sv
module systick_tick_sel #(
   parameter bit EXT_TICK_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic use_core,
   input  logic ref_tick,
   output logic tick
);

   generate
      if (EXT_TICK_REG) begin : g_reg
         logic ref_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ref_q <= 1'b0;
            else        ref_q <= ref_tick;
         end
         assign tick = use_core | ref_q;
      end else begin : g_direct
         assign tick = use_core | ref_tick;
      end
   endgenerate

endmodule

// File: rtl/systick_core.sv
module systick_core
   import systick_pkg::*;
#(
   parameter int COUNT_W = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  strobe_t            stb,
   input  logic [2:0]         ctrl_wdata,
   input  logic [COUNT_W-1:0] reload_wdata,
   input  logic               tick,
   output logic               run_q,
   output logic               irqen_q,
   output logic               src_q,
   output logic               flag_q,
   output logic [COUNT_W-1:0] reload_q,
   output logic [COUNT_W-1:0] count_q,
   output logic               irq_q
);

   if (COUNT_W < 1 || COUNT_W > 32) begin : g_bad_width
      $error("systick_core: COUNT_W must lie in 1..32");
   end

   logic held_q;     // frozen count waiting to resume
   logic count_ok;
   logic expire;
   logic new_run;
   logic new_src;

   assign new_run  = ctrl_wdata[BIT_RUN];
   assign new_src  = ctrl_wdata[BIT_SRC];
   assign count_ok = run_q && tick && !stb.wr_ctrl && !stb.wr_count;
   assign expire   = count_ok && (count_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         irqen_q  <= 1'b0;
         src_q    <= 1'b0;
         flag_q   <= 1'b0;
         held_q   <= 1'b0;
         reload_q <= '0;
         count_q  <= '0;
         irq_q    <= 1'b0;
      end else begin
         irq_q <= expire && irqen_q;
         if (stb.wr_reload) reload_q <= reload_wdata;
         if (stb.rd_ctrl)   flag_q   <= 1'b0;
         if (stb.wr_ctrl) begin
            run_q   <= new_run;
            irqen_q <= ctrl_wdata[BIT_IRQEN];
            src_q   <= new_src;
            if (!run_q && new_run) begin
               if (!held_q) count_q <= reload_q;
               held_q <= 1'b0;
            end else if (run_q && !new_run) begin
               held_q <= 1'b1;
            end else if (run_q && (new_src != src_q)) begin
               count_q <= reload_q;
            end
         end else if (stb.wr_count) begin
            flag_q <= 1'b0;
            held_q <= 1'b0;
            if (run_q) count_q <= reload_q;
         end else if (count_ok) begin
            if (count_q == '0) begin
               flag_q <= 1'b1;
               if (reload_q == '0) run_q   <= 1'b0;
               else                count_q <= reload_q;
            end else begin
               count_q <= count_q - 1'b1;
            end
         end
      end
   end

   assert_irq_single_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |=> !irq_q);
   assert_irq_flag_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> flag_q);
   assert_zero_reload_stop_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (expire && reload_q == '0) |=> !run_q);
   assert_count_restart_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (stb.wr_count && run_q) |=> (count_q == $past(reload_q)) && !flag_q);
   assert_freeze_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !stb.wr_ctrl) |=> $stable(count_q));
   assert_flag_kept_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (stb.wr_ctrl && !stb.rd_ctrl) |=> flag_q == $past(flag_q));
   assert_src_reload_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (stb.wr_ctrl && run_q && new_run && (new_src != src_q)) |=> count_q == $past(reload_q));

endmodule

// File: rtl/systick_timer.sv
module systick_timer
   import systick_pkg::*;
#(
   parameter int          ADDR_W       = 8,
   parameter int          COUNT_W      = 24,
   parameter int unsigned CAL_VALUE    = 10000,
   parameter bit          EXT_TICK_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_rd,
   output logic [31:0]       bus_rdata,
   input  logic              ref_tick,
   output logic              tick_irq
);

   if (ADDR_W < 4) begin : g_bad_addr
      $error("systick_timer: ADDR_W must be at least 4");
   end

   localparam logic [31:0] CAL_WORD = 32'(CAL_VALUE);

   strobe_t            stb;
   rsel_e              rsel;
   logic               tick;
   logic               run_q, irqen_q, src_q, flag_q;
   logic [COUNT_W-1:0] reload_q, count_q;
   logic               unused_wdata;

   assign unused_wdata = ^bus_wdata;

   systick_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr (bus_addr),
      .wr   (bus_wr),
      .rd   (bus_rd),
      .stb  (stb),
      .rsel (rsel)
   );

   systick_tick_sel #(.EXT_TICK_REG(EXT_TICK_REG)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .use_core (src_q),
      .ref_tick (ref_tick),
      .tick     (tick)
   );

   systick_core #(.COUNT_W(COUNT_W)) u_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .stb          (stb),
      .ctrl_wdata   (bus_wdata[2:0]),
      .reload_wdata (bus_wdata[COUNT_W-1:0]),
      .tick         (tick),
      .run_q        (run_q),
      .irqen_q      (irqen_q),
      .src_q        (src_q),
      .flag_q       (flag_q),
      .reload_q     (reload_q),
      .count_q      (count_q),
      .irq_q        (tick_irq)
   );

   always_comb begin
      bus_rdata = '0;
      unique case (rsel)
         RSEL_CTRL: begin
            bus_rdata[BIT_RUN]   = run_q;
            bus_rdata[BIT_IRQEN] = irqen_q;
            bus_rdata[BIT_SRC]   = src_q;
            bus_rdata[BIT_FLAG]  = flag_q;
         end
         RSEL_RELOAD: bus_rdata = 32'(reload_q);
         RSEL_COUNT:  bus_rdata = run_q ? 32'(count_q) : '0;
         RSEL_CALIB:  bus_rdata = CAL_WORD;
         default:     bus_rdata = '0;
      endcase
   end

   assert_idle_bus_zero_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> bus_rdata == '0);

endmodule

// File: tb/systick_timer_test.sv
module systick_timer_test;

   localparam int          AW   = 8;
   localparam int          CW   = 12;
   localparam int unsigned CAL  = 10000;
   localparam bit          EXTR = 1'b1;
   localparam int unsigned MASK = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          wr = 1'b0, rd = 1'b0, reft = 1'b0;
   logic [31:0]   wd = '0;
   wire  [31:0]   rdata;
   wire           irq;

   always #4 clk = ~clk;

   systick_timer #(.ADDR_W(AW), .COUNT_W(CW), .CAL_VALUE(CAL), .EXT_TICK_REG(EXTR)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wd),
      .bus_rd(rd), .bus_rdata(rdata), .ref_tick(reft), .tick_irq(irq)
   );

   int    checks = 0;
   int    fails  = 0;
   string req    = "R1";

   // behavioural reference state
   bit          m_en, m_ie, m_cs, m_flag, m_held, m_irq, m_extq;
   int unsigned m_rel, m_cur;

   function automatic logic [31:0] m_rdata();
      if (!rd) return 32'h0;
      case (addr)
         8'h00:   return {15'd0, m_flag, 13'd0, m_cs, m_ie, m_en};
         8'h04:   return m_rel;
         8'h08:   return m_en ? m_cur : 32'h0;
         8'h0C:   return CAL;
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk) begin : model
      bit          tk;
      bit          nirq;
      int unsigned nrel;
      if (!rst_n) begin
         m_en = 0; m_ie = 0; m_cs = 0; m_flag = 0; m_held = 0;
         m_irq = 0; m_extq = 0; m_rel = 0; m_cur = 0;
      end else begin
         tk     = m_cs || (EXTR ? m_extq : reft);
         m_extq = reft;
         nirq   = 0;
         nrel   = m_rel;
         if (wr && addr == 8'h04) nrel = wd & MASK;
         if (rd && addr == 8'h00) m_flag = 0;
         if (wr && addr == 8'h00) begin
            if (!m_en && wd[0]) begin
               if (!m_held) m_cur = m_rel;
               m_held = 0;
            end else if (m_en && !wd[0]) m_held = 1;
            else if (m_en && wd[2] != m_cs) m_cur = m_rel;
            m_en = wd[0]; m_ie = wd[1]; m_cs = wd[2];
         end else if (wr && addr == 8'h08) begin
            m_flag = 0; m_held = 0;
            if (m_en) m_cur = m_rel;
         end else if (m_en && tk) begin
            if (m_cur == 0) begin
               m_flag = 1; nirq = m_ie;
               if (m_rel == 0) m_en = 0; else m_cur = m_rel;
            end else m_cur = m_cur - 1;
         end
         m_rel = nrel;
         m_irq = nirq;
      end
   end

   task automatic step(input bit w, input logic [7:0] a, input logic [31:0] d,
                       input bit r, input bit t);
      logic [31:0] e;
      @(negedge clk);
      wr = w; addr = a; wd = d; rd = r; reft = t;
      #1;
      checks++;
      if (irq !== m_irq) begin
         fails++;
         $display("FAIL %s tick_irq: got %0b expected %0b", req, irq, m_irq);
      end
      e = m_rdata();
      checks++;
      if (rdata !== e) begin
         fails++;
         $display("FAIL %s rdata @%h: got %h expected %h", req, a, rdata, e);
      end
   endtask

   task automatic idle(input int n, input int period);
      for (int i = 0; i < n; i++)
         step(0, 8'h00, 32'h0, 0, (period != 0) && (i % period == 0));
   endtask

   task automatic rd_lit(input logic [7:0] a, input logic [31:0] mask, input logic [31:0] exp);
      step(0, a, 32'h0, 1, 0);
      checks++;
      if ((rdata & mask) !== exp) begin
         fails++;
         $display("FAIL %s literal read @%h: got %h expected %h", req, a, rdata & mask, exp);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired: got hang expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : stim
      logic [15:0] lf;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      req = "R1";
      rd_lit(8'h00, 32'hFFFF_FFFF, 32'h0);
      rd_lit(8'h04, 32'hFFFF_FFFF, 32'h0);
      rd_lit(8'h08, 32'hFFFF_FFFF, 32'h0);
      req = "R13";
      rd_lit(8'h0C, 32'hFFFF_FFFF, 32'd10000);
      step(1, 8'h0C, 32'h5, 0, 0);
      rd_lit(8'h0C, 32'hFFFF_FFFF, 32'd10000);

      req = "R12";
      step(1, 8'h04, 32'h000A_BCDE, 0, 0);
      rd_lit(8'h04, 32'hFFFF_FFFF, 32'h0000_0CDE);

      req = "R2";
      rd_lit(8'h10, 32'hFFFF_FFFF, 32'h0);
      rd_lit(8'h05, 32'hFFFF_FFFF, 32'h0);
      step(1, 8'h06, 32'h7, 0, 0);
      step(1, 8'h14, 32'h3, 0, 0);
      step(1, 8'h01, 32'h7, 0, 0);
      rd_lit(8'h04, 32'hFFFF_FFFF, 32'h0000_0CDE);
      rd_lit(8'h00, 32'hFFFF_FFFF, 32'h0);

      req = "R5";
      step(1, 8'h04, 32'd4, 0, 0);
      step(1, 8'h00, 32'h5, 0, 0);
      rd_lit(8'h08, 32'hFFFF_FFFF, 32'd4);
      rd_lit(8'h08, 32'hFFFF_FFFF, 32'd3);
      idle(2, 0);
      rd_lit(8'h00, 32'h0001_0000, 32'h0);
      req = "R4";
      rd_lit(8'h00, 32'h0001_0000, 32'h0001_0000);
      rd_lit(8'h00, 32'h0001_0000, 32'h0);

      req = "R6";
      step(1, 8'h00, 32'h7, 0, 0);
      idle(20, 0);
      rd_lit(8'h08, 32'h0, 32'h0);

      req = "R14";
      step(1, 8'h08, 32'hDEAD_BEEF, 0, 0);
      rd_lit(8'h08, 32'hFFFF_FFFF, 32'd4);
      req = "R8";
      idle(3, 0);
      step(1, 8'h08, 32'h0, 0, 0);
      rd_lit(8'h00, 32'h0001_0000, 32'h0);
      idle(6, 0);

      req = "R10";
      step(1, 8'h04, 32'd6, 0, 0);
      step(1, 8'h00, 32'h3, 0, 0);
      rd_lit(8'h08, 32'hFFFF_FFFF, 32'd6);
      req = "R9";
      idle(40, 3);

      req = "R11";
      step(1, 8'h00, 32'h6, 0, 0);
      rd_lit(8'h08, 32'hFFFF_FFFF, 32'h0);
      idle(5, 0);
      step(1, 8'h00, 32'h7, 0, 0);
      rd_lit(8'h08, 32'h0, 32'h0);
      idle(4, 0);
      step(1, 8'h00, 32'h6, 0, 0);
      step(1, 8'h08, 32'h1, 0, 0);
      step(1, 8'h00, 32'h7, 0, 0);
      rd_lit(8'h08, 32'hFFFF_FFFF, 32'd6);

      req = "R7";
      step(1, 8'h00, 32'h0, 0, 0);
      step(1, 8'h04, 32'h0, 0, 0);
      step(1, 8'h08, 32'h0, 0, 0);
      rd_lit(8'h00, 32'h0001_0000, 32'h0);
      step(1, 8'h00, 32'h7, 0, 0);
      idle(3, 0);
      rd_lit(8'h00, 32'h0001_0001, 32'h0001_0000);

      req = "R3";
      step(1, 8'h00, 32'hFFFF_FFFA, 0, 0);
      rd_lit(8'h00, 32'hFFFE_FFF8, 32'h0);
      rd_lit(8'h00, 32'h0000_0007, 32'h2);

      req = "R4 R14";
      lf = 16'hACE1;
      for (int i = 0; i < 3000; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         case (lf[2:0])
            3'd0:    step(1, 8'h00, {29'd0, lf[5] | lf[6], lf[4], lf[3] | lf[7]}, 0, lf[9]);
            3'd1:    step(1, 8'h04, {28'd0, lf[6:3] & 4'h7}, 0, lf[9]);
            3'd2:    step(lf[3] & lf[4], 8'h08, {16'd0, lf}, 1, lf[9]);
            3'd3:    step(0, 8'h00, 32'h0, 1, lf[9]);
            3'd4:    step(0, 8'h08, 32'h0, 1, lf[9]);
            default: step(0, {4'd0, lf[8:5]}, 32'h0, 1, lf[9]);
         endcase
      end
      idle(4, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule